// File: doc/BRIEF.md
# Synchronous Rendezvous Message Channel

This block joins exactly one sending port to exactly one receiving port and moves a message of one or more bytes between them as a blocking rendezvous. Each side announces itself by holding a request high together with a length field. Whichever side shows up first is parked: nothing moves, and nothing on its interface toggles, until its partner also requests. When both are present and their length fields agree, the channel streams the bytes from sender to receiver at one byte per clock. It then pulses the done output on both sides in the same cycle, which releases both sides together. No byte is ever stored ahead of the receiver. The sender's data bus feeds the receiver's data bus in the same cycle that the sender is told its byte was taken.

The ports behave the same way whether the partner logic sits nearby or far away. A client only sees request, length, data and done. If the two length fields disagree, the channel raises an error flag and releases neither side. The flag clears once either side withdraws its request.

Top module: `rendezvous_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the channel returns to idle. After that edge, `tx_take`, `rx_valid`, `tx_done`, `rx_done` and `len_err` are all 0.
- R2: If only `tx_req` is high, the sender is parked. `tx_take`, `rx_valid`, `tx_done` and `rx_done` stay 0 for as long as the receiver stays away.
- R3: If only `rx_req` is high, the receiver is parked in the same way. No take, valid or done is asserted.
- R4: At the first clock edge where both requests are high and the lengths match, a transfer starts. `rx_valid` and `tx_take` are 1 in the cycle that follows that edge, whichever side arrived first.
- R5: The length field holds the byte count minus one, so a value k moves k+1 bytes. During the transfer, `rx_valid` and `tx_take` are high for exactly k+1 consecutive cycles, one byte per cycle. In each of those cycles `rx_data` equals the `tx_data` the sender presents.
- R6: `tx_done` and `rx_done` are both 1 in the single cycle right after the last byte cycle. They are 0 in every other cycle.
- R7: If both requests are high at an edge with unequal length fields, `len_err` is 1 after that edge and no byte moves and no done pulses. `len_err` returns to 0 after the first edge at which either request is low.
- R8: A reset during a transfer drops it. After the reset edge there is no `rx_valid`, no `tx_take` and no done pulse for the dropped message.
- R9: The boundary lengths work: field 0 moves one byte, and the all-ones field moves 2^LEN_W bytes.
- R10: After a done pulse, the sides may drop and raise their requests again, and a new rendezvous proceeds normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | Sender ready; held until `tx_done` |
| tx_len | input | LEN_W | Sender byte count minus one |
| tx_data | input | DATA_W | Byte offered by the sender |
| tx_take | output | 1 | Current `tx_data` byte is consumed this cycle |
| tx_done | output | 1 | One-cycle release pulse to the sender |
| rx_req | input | 1 | Receiver ready; held until `rx_done` |
| rx_len | input | LEN_W | Receiver byte count minus one |
| rx_data | output | DATA_W | Byte delivered to the receiver |
| rx_valid | output | 1 | `rx_data` carries a message byte this cycle |
| rx_done | output | 1 | One-cycle release pulse to the receiver |
| len_err | output | 1 | Both sides present with unequal length fields |

## Verification
The main function is tried with the sender arriving first, with the receiver arriving first, and with both arriving in the same cycle. The first two separate the two parked states, and the third checks the direct start from idle. Lengths of one byte, a few bytes and the full 256 bytes tell a counter that stops early or late apart from a correct one. A distinct byte pattern per message exposes reordering or a repeated byte. Unequal lengths, a reset in the middle of a message, and a back-to-back pair of messages check the error hold, the dropping of a partial transfer and the release back to idle.

// File: rtl/rvc_pkg.sv
// Shared types for the rendezvous channel.
// Holds the channel state encoding and the arbitration rule used while no
// transfer is running. Assumes nothing beyond a two-party channel.
package rvc_pkg;

    typedef enum logic [2:0] {
        CH_IDLE     = 3'd0,
        CH_SND_WAIT = 3'd1,
        CH_RCV_WAIT = 3'd2,
        CH_XFER     = 3'd3,
        CH_DONE     = 3'd4
    } ch_state_t;

    // Next state of an idle or parked channel from the two requests.
    function automatic ch_state_t arbitrate(input logic snd, input logic rcv,
                                            input logic same_len);
        ch_state_t nxt;
        if (snd && rcv)
            nxt = same_len ? CH_XFER : CH_IDLE;
        else if (snd)
            nxt = CH_SND_WAIT;
        else if (rcv)
            nxt = CH_RCV_WAIT;
        else
            nxt = CH_IDLE;
        return nxt;
    endfunction

endpackage

// File: rtl/rvc_lencheck.sv
// Length agreement check.
// Compares the two length fields bit by bit and keeps an error flag while
// both sides are present with unequal lengths during arbitration.
// Assumes the controller marks arbitration phases with arb_phase.
module rvc_lencheck #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_phase,
    input  logic             tx_req,
    input  logic             rx_req,
    input  logic [LEN_W-1:0] tx_len,
    input  logic [LEN_W-1:0] rx_len,
    output logic             lens_match,
    output logic             err_q
);

    logic [LEN_W-1:0] bit_eq;

    // Per-bit equality of the two length fields.
    for (genvar b = 0; b < LEN_W; b++) begin : g_eq
        assign bit_eq[b] = ~(tx_len[b] ^ rx_len[b]);
    end

    assign lens_match = &bit_eq;

    // Error flag: set on a mismatched meeting, cleared when a side leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= arb_phase && tx_req && rx_req && !lens_match;
    end

    // R7: a raised flag means both sides were present at the previous edge.
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(tx_req) && $past(rx_req));

endmodule

// File: rtl/rvc_counter.sv
// Byte down-counter.
// Loads the length field (byte count minus one) at the start of a message
// and steps down once per transferred byte; zero marks the last byte.
// Assumes load and run are never high together.
module rvc_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [LEN_W-1:0] len_in,
    output logic             cnt_zero
);

    logic [LEN_W-1:0] cnt;

    // Remaining-bytes register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len_in;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign cnt_zero = (cnt == '0);

    // R5: each running byte that is not the last lowers the count by one.
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_zero) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/rvc_ctrl.sv
// Rendezvous controller.
// Parks the side that arrives first, starts a transfer when both are present
// with matching lengths, runs one byte per cycle until the counter reports
// the last byte, then issues one shared release cycle.
// Assumes requests stay high until the release pulse.
module rvc_ctrl
    import rvc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_req,
    input  logic      rx_req,
    input  logic      lens_match,
    input  logic      cnt_zero,
    output ch_state_t state,
    output logic      arb_phase,
    output logic      load,
    output logic      run,
    output logic      release_pulse
);

    ch_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE, CH_SND_WAIT, CH_RCV_WAIT:
                nxt = arbitrate(tx_req, rx_req, lens_match);
            CH_XFER:
                nxt = cnt_zero ? CH_DONE : CH_XFER;
            CH_DONE:
                nxt = CH_IDLE;
            default:
                nxt = CH_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= CH_IDLE;
        else
            state <= nxt;
    end

    assign arb_phase     = (state == CH_IDLE) || (state == CH_SND_WAIT) ||
                           (state == CH_RCV_WAIT);
    assign load          = arb_phase && (nxt == CH_XFER);
    assign run           = (state == CH_XFER);
    assign release_pulse = (state == CH_DONE);

    // R1: reset always leaves the channel idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> state == CH_IDLE);

    // R6: the release cycle follows directly on the last byte.
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> $past(run) && $past(cnt_zero));

    // R5: a transfer never ends before the counter reaches zero.
    p_no_early_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_zero) |=> run);

endmodule

// File: rtl/rendezvous_channel.sv
// Synchronous rendezvous message channel (top).
// One sender and one receiver meet here; the first to arrive waits until the
// other requests, then bytes stream straight through at one per clock and
// both sides are released in the same cycle. Assumes each side holds its
// request, length and (for the sender) data until told otherwise.
module rendezvous_channel
    import rvc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_req,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_take,
    output logic              tx_done,
    input  logic              rx_req,
    input  logic [LEN_W-1:0]  rx_len,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_done,
    output logic              len_err
);

    ch_state_t state;
    logic      arb_phase;
    logic      load;
    logic      run;
    logic      release_pulse;
    logic      lens_match;
    logic      cnt_zero;

    rvc_lencheck #(.LEN_W(LEN_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .arb_phase  (arb_phase),
        .tx_req     (tx_req),
        .rx_req     (rx_req),
        .tx_len     (tx_len),
        .rx_len     (rx_len),
        .lens_match (lens_match),
        .err_q      (len_err)
    );

    rvc_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .run      (run),
        .len_in   (tx_len),
        .cnt_zero (cnt_zero)
    );

    rvc_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_req        (tx_req),
        .rx_req        (rx_req),
        .lens_match    (lens_match),
        .cnt_zero      (cnt_zero),
        .state         (state),
        .arb_phase     (arb_phase),
        .load          (load),
        .run           (run),
        .release_pulse (release_pulse)
    );

    // Straight-through byte path; quiet outside a transfer.
    always_comb begin
        rx_data  = run ? tx_data : '0;
        rx_valid = run;
        tx_take  = run;
        tx_done  = release_pulse;
        rx_done  = release_pulse;
    end

    // R4: the first byte cycle is preceded by both sides requesting.
    p_start_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(tx_req) && $past(rx_req));

    // R7: while the length error stands nothing moves and nobody is released.
    p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !rx_valid && !tx_done && !rx_done);

    // R2: a lone sender never sees its bytes taken.
    p_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_SND_WAIT) |-> !tx_take && !tx_done);

endmodule

// File: tb/sim_rendezvous_channel.sv
// Directed bench for the rendezvous channel.
module sim_rendezvous_channel;

    localparam int  DATA_W = 8;
    localparam int  LEN_W  = 8;
    localparam time TCLK   = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_req = 1'b0;
    logic [LEN_W-1:0]  tx_len = '0;
    logic [DATA_W-1:0] tx_data = '0;
    logic              tx_take;
    logic              tx_done;
    logic              rx_req = 1'b0;
    logic [LEN_W-1:0]  rx_len = '0;
    logic [DATA_W-1:0] rx_data;
    logic              rx_valid;
    logic              rx_done;
    logic              len_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    rendezvous_channel #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u0 (.*);

    always #(TCLK/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 31 + i * 7 + 3) & 8'hFF);
    endfunction

    // Quiet outputs: no take, valid or done.
    task automatic expect_quiet(input string req);
        check(req, {29'b0, tx_take, rx_valid, tx_done | rx_done}, 32'd0);
    endtask

    // One full rendezvous; tx_at/rx_at are the negedges at which each arrives.
    task automatic do_xfer(input int k, input int tx_at, input int rx_at,
                           input int seed, input string req);
        int both = (tx_at > rx_at) ? tx_at : rx_at;
        for (int c = 0; c <= both; c++) begin
            @(negedge clk);
            if (c > 0) begin
                expect_quiet(tx_at < rx_at ? "R2" : "R3");
                check(req, {31'b0, len_err}, 32'd0);
            end
            if (c == tx_at) begin
                tx_req = 1'b1; tx_len = LEN_W'(k); tx_data = pat(seed, 0);
            end
            if (c == rx_at) begin
                rx_req = 1'b1; rx_len = LEN_W'(k);
            end
        end
        for (int i = 0; i <= k; i++) begin
            @(negedge clk);
            check({req, " R4/R5 valid"}, {30'b0, rx_valid, tx_take}, 32'd3);
            check({req, " R5 data"}, {24'b0, rx_data}, {24'b0, pat(seed, i)});
            check({req, " R6 early"}, {31'b0, tx_done | rx_done}, 32'd0);
            tx_data = pat(seed, i + 1);
        end
        @(negedge clk);
        check({req, " R6 done"}, {29'b0, tx_done, rx_done, rx_valid}, 32'd6);
        tx_req = 1'b0; rx_req = 1'b0;
        @(negedge clk);
        check({req, " R6 single"}, {30'b0, tx_done, rx_done}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 outputs", {27'b0, tx_take, rx_valid, tx_done, rx_done, len_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_quiet("R1 idle");
    endtask

    task automatic t_mismatch();
        @(negedge clk);
        tx_req = 1'b1; tx_len = 8'd3; rx_req = 1'b1; rx_len = 8'd5;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R7 err", {31'b0, len_err}, 32'd1);
            expect_quiet("R7 held");
        end
        rx_req = 1'b0;
        @(negedge clk);
        check("R7 clear", {31'b0, len_err}, 32'd0);
        expect_quiet("R7 clear");
        tx_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        tx_req = 1'b1; rx_req = 1'b1; tx_len = 8'd9; rx_len = 8'd9; tx_data = 8'h11;
        for (int c = 0; c < 3; c++) @(negedge clk);
        check("R8 running", {31'b0, rx_valid}, 32'd1);
        rst_n = 1'b0; tx_req = 1'b0; rx_req = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            expect_quiet("R8 dropped");
        end
        rst_n = 1'b1;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            expect_quiet("R8 no resume");
        end
    endtask

    initial begin
        for (int n = 0; n < 150000; n++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        do_xfer(4, 0, 3, 1, "R2 sender first");
        do_xfer(2, 4, 1, 2, "R3 receiver first");
        do_xfer(6, 0, 0, 3, "R4 together");
        do_xfer(0, 0, 0, 4, "R9 one byte");
        do_xfer(255, 1, 0, 5, "R9 max length");
        t_mismatch();
        t_reset_mid();
        do_xfer(3, 0, 0, 6, "R10 first");
        do_xfer(5, 0, 1, 7, "R10 second");
        finish_run();
    end

endmodule